// File: doc/BRIEF.md
# Transaction Timeout and Slow-Start Governor

This block sits on a node's request issue path and decides whether each new coherence transaction may be issued. Every issued transaction occupies a tracking slot, and the block returns the slot index with the grant. A completion names the slot it frees. Each slot counts checkpoint ticks from the moment it is allocated. A transaction that is still open after `TIMEOUT_TICKS` ticks is taken as a sign of deadlock, and the block raises a request for system recovery. The block has no view of the network, so the timeout is its only means of detecting a deadlock.

Recovery rolls the whole node back, so the block drops all of its tracked transactions when the recovery-done pulse arrives. The first recovery after a clean run puts the block in a retry mode. Retry keeps the full issue width and leaves adaptive routing on, in the hope that the race does not come back. If the block times out again before it has seen enough clean completions, the next recovery puts it in slow-start. Slow-start allows at most `SLOW_LIMIT` open transactions and turns adaptive routing off. Either fallback mode returns to normal after `EXIT_COUNT` completions without a timeout.

A parameter selects what happens to adaptive routing when slow-start ends. It can be turned back on at that point, or it can stay off for good. The tick input is expected to pulse once per checkpoint interval, which is typically 100,000 cycles.

Top module: `txn_timeout_governor`

## Requirements
- R1: After reset, `recov_req` is 0, `gov_mode` is 0 (normal), `adapt_route_en` is 1, and no slot is occupied.
- R2: `issue_grant` equals `issue_req` whenever no recovery is pending and the occupied-slot count is below the current limit. While it is high, `grant_slot` gives the lowest-numbered free slot, and that slot is occupied from the next clock edge.
- R3: In normal mode (0) and retry mode (1), the limit is `NUM_SLOTS`. A request that arrives while all slots are occupied is refused.
- R4: An occupied slot that sees its `TIMEOUT_TICKS`-th `ckpt_tick` without a completion raises `recov_req` in the following cycle. A completion before that tick prevents the timeout.
- R5: `recov_req` stays high until `recov_done` is sampled. While `recov_req` is high, `issue_grant` is 0. `recov_done` frees every slot.
- R6: A recovery taken in normal mode moves `gov_mode` to 1 (retry), with `adapt_route_en` kept at 1.
- R7: A recovery taken in retry or slow-start mode moves `gov_mode` to 2 (slow-start). In slow-start, the limit is `SLOW_LIMIT` and `adapt_route_en` is 0.
- R8: In mode 1 or 2, the `EXIT_COUNT`-th completion since the mode was entered returns `gov_mode` to 0 in the next cycle. Completions sampled while a recovery is pending are not counted.
- R9: With `ROUTE_POLICY` = 0, `adapt_route_en` returns to 1 when slow-start ends. With `ROUTE_POLICY` = 1, it stays 0 once slow-start has been entered.
- R10: A completion that names a free slot has no effect. When a completion and a tick arrive for the same slot in the same cycle, the completion wins and no timeout is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_req | input | 1 | A new transaction wants to issue |
| issue_grant | output | 1 | Issue allowed this cycle |
| grant_slot | output | SLOT_W | Slot assigned to the granted transaction |
| done_valid | input | 1 | A transaction completed |
| done_slot | input | SLOT_W | Slot of the completed transaction |
| ckpt_tick | input | 1 | One pulse per checkpoint interval |
| recov_done | input | 1 | System recovery finished |
| recov_req | output | 1 | Request for system recovery |
| adapt_route_en | output | 1 | Adaptive routing permitted |
| gov_mode | output | 2 | 0 normal, 1 retry, 2 slow-start |

## Verification
Directed sequences fill every slot and then request once more, which tells the full-width limit apart from the slow-start limit of one. A completion arrives on the same tick as a slot's last tick, which shows whether the completion or the timeout takes priority. Chained timeouts step the mode from normal to retry and then to slow-start, and clean completions, including one that names a free slot, show whether the exit counter counts only real completions. A long randomized mix of requests, completions, ticks and recovery pulses is then compared every cycle against a behavioural model. Two instances differ only in their routing policy, which separates re-enabling adaptive routing after slow-start from keeping it off permanently.

// File: rtl/tog_pkg.sv
package tog_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_RETRY  = 2'd1,
    MODE_SLOW   = 2'd2
  } gov_mode_e;
endpackage

// File: rtl/tog_slot_bank.sv
// One tick counter per transaction slot; reports any timeout.
module tog_slot_bank #(
  parameter int NUM_SLOTS     = 4,
  parameter int TIMEOUT_TICKS = 3,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int CNT_W  = $clog2(TIMEOUT_TICKS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] alloc_vec,
  input  logic                 done_valid,
  input  logic [SLOT_W-1:0]    done_slot,
  input  logic                 ckpt_tick,
  input  logic                 flush,
  output logic [NUM_SLOTS-1:0] active,
  output logic                 timeout_hit
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_TICKS - 1);
  localparam logic [CNT_W-1:0] SAT_CNT  = CNT_W'(TIMEOUT_TICKS);

  logic [NUM_SLOTS-1:0] hit_vec;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic             act_q, act_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             done_here;
    logic             cnt_en;

    assign done_here = done_valid && (done_slot == SLOT_W'(s)) && act_q;

    always_comb begin
      act_d  = act_q;
      cnt_d  = cnt_q;
      cnt_en = 1'b0;
      if (flush) begin
        act_d  = 1'b0;
        cnt_d  = '0;
        cnt_en = 1'b1;
      end else if (alloc_vec[s]) begin
        act_d  = 1'b1;
        cnt_d  = '0;
        cnt_en = 1'b1;
      end else if (done_here) begin
        act_d  = 1'b0;
      end else if (ckpt_tick && act_q && (cnt_q != SAT_CNT)) begin
        cnt_d  = cnt_q + CNT_W'(1);
        cnt_en = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q <= 1'b0;
      end else begin
        act_q <= act_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end

    assign hit_vec[s] = act_q && ckpt_tick && !done_here && !flush &&
                        (cnt_q == LAST_CNT);
    assign active[s]  = act_q;
  end

  assign timeout_hit = |hit_vec;
endmodule

// File: rtl/tog_alloc.sv
// Lowest-free-slot search and occupancy count.
module tog_alloc #(
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int OCC_W  = $clog2(NUM_SLOTS + 1)
) (
  input  logic [NUM_SLOTS-1:0] active,
  output logic [SLOT_W-1:0]    free_idx,
  output logic [OCC_W-1:0]     occ_cnt
);
  always_comb begin
    free_idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!active[i]) free_idx = SLOT_W'(i);
    end
  end

  always_comb begin
    occ_cnt = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      occ_cnt = occ_cnt + OCC_W'(active[i]);
    end
  end
endmodule

// File: rtl/tog_mode_ctrl.sv
// Recovery request and normal / retry / slow-start sequencing.
module tog_mode_ctrl
  import tog_pkg::*;
#(
  parameter int EXIT_COUNT   = 4,
  parameter int ROUTE_POLICY = 0,
  localparam int EXIT_W = $clog2(EXIT_COUNT + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      timeout_hit,
  input  logic      recov_done,
  input  logic      completion,
  output logic      recov_req,
  output gov_mode_e mode,
  output logic      adapt_en
);
  localparam logic [EXIT_W-1:0] EXIT_LAST = EXIT_W'(EXIT_COUNT - 1);

  gov_mode_e         mode_q, mode_d;
  logic              req_q, req_d;
  logic [EXIT_W-1:0] exit_q, exit_d;
  logic              lock_q, lock_d;
  logic              recov_take;

  assign recov_take = req_q && recov_done;

  always_comb begin
    req_d = req_q;
    if (req_q) begin
      if (recov_done) req_d = 1'b0;
    end else if (timeout_hit) begin
      req_d = 1'b1;
    end
  end

  always_comb begin
    mode_d = mode_q;
    exit_d = exit_q;
    lock_d = lock_q;
    if (recov_take) begin
      exit_d = '0;
      if (mode_q == MODE_NORMAL) begin
        mode_d = MODE_RETRY;
      end else begin
        mode_d = MODE_SLOW;
        if (ROUTE_POLICY != 0) lock_d = 1'b1;
      end
    end else if (!req_q && completion && (mode_q != MODE_NORMAL)) begin
      if (exit_q == EXIT_LAST) begin
        mode_d = MODE_NORMAL;
        exit_d = '0;
      end else begin
        exit_d = exit_q + EXIT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      mode_q <= MODE_NORMAL;
      exit_q <= '0;
      lock_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      mode_q <= mode_d;
      exit_q <= exit_d;
      lock_q <= lock_d;
    end
  end

  assign recov_req = req_q;
  assign mode      = mode_q;
  assign adapt_en  = (mode_q != MODE_SLOW) && !lock_q;
endmodule

// File: rtl/txn_timeout_governor.sv
module txn_timeout_governor
  import tog_pkg::*;
#(
  parameter int NUM_SLOTS     = 4,
  parameter int TIMEOUT_TICKS = 3,
  parameter int SLOW_LIMIT    = 1,
  parameter int EXIT_COUNT    = 4,
  parameter int ROUTE_POLICY  = 0,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_req,
  output logic              issue_grant,
  output logic [SLOT_W-1:0] grant_slot,
  input  logic              done_valid,
  input  logic [SLOT_W-1:0] done_slot,
  input  logic              ckpt_tick,
  input  logic              recov_done,
  output logic              recov_req,
  output logic              adapt_route_en,
  output logic [1:0]        gov_mode
);
  localparam int OCC_W = $clog2(NUM_SLOTS + 1);
  localparam logic [OCC_W-1:0] FULL_LIM = OCC_W'(NUM_SLOTS);
  localparam logic [OCC_W-1:0] SLOW_LIM = OCC_W'(SLOW_LIMIT);

  logic [NUM_SLOTS-1:0] active;
  logic [NUM_SLOTS-1:0] alloc_vec;
  logic [SLOT_W-1:0]    free_idx;
  logic [OCC_W-1:0]     occ_cnt;
  logic [OCC_W-1:0]     occ_lim;
  logic                 timeout_hit;
  logic                 completion;
  logic                 flush;
  gov_mode_e            mode;

  tog_alloc #(.NUM_SLOTS(NUM_SLOTS)) u_alloc (
    .active   (active),
    .free_idx (free_idx),
    .occ_cnt  (occ_cnt)
  );

  assign occ_lim     = (mode == MODE_SLOW) ? SLOW_LIM : FULL_LIM;
  assign issue_grant = issue_req && !recov_req && (occ_cnt < occ_lim);
  assign grant_slot  = free_idx;
  assign flush       = recov_req && recov_done;
  assign completion  = done_valid && active[done_slot];

  always_comb begin
    alloc_vec = '0;
    if (issue_grant) alloc_vec[free_idx] = 1'b1;
  end

  tog_slot_bank #(
    .NUM_SLOTS     (NUM_SLOTS),
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
  ) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_vec   (alloc_vec),
    .done_valid  (done_valid),
    .done_slot   (done_slot),
    .ckpt_tick   (ckpt_tick),
    .flush       (flush),
    .active      (active),
    .timeout_hit (timeout_hit)
  );

  tog_mode_ctrl #(
    .EXIT_COUNT   (EXIT_COUNT),
    .ROUTE_POLICY (ROUTE_POLICY)
  ) u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .timeout_hit (timeout_hit),
    .recov_done  (recov_done),
    .completion  (completion),
    .recov_req   (recov_req),
    .mode        (mode),
    .adapt_en    (adapt_route_en)
  );

  assign gov_mode = mode;
endmodule

// File: rtl/txn_timeout_governor_chk.sv
module txn_timeout_governor_chk #(
  parameter int NUM_SLOTS  = 4,
  parameter int SLOW_LIMIT = 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 issue_grant,
  input logic                 recov_req,
  input logic                 recov_done,
  input logic                 done_valid,
  input logic                 adapt_route_en,
  input logic [1:0]           gov_mode,
  input logic [NUM_SLOTS-1:0] active
);
  a_r5_no_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
    recov_req |-> !issue_grant);

  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (recov_req && !recov_done) |=> recov_req);

  a_r5_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
    (recov_req && recov_done) |=> (active == '0));

  a_r7_slow_no_adapt: assert property (@(posedge clk) disable iff (!rst_n)
    (gov_mode == 2'd2) |-> !adapt_route_en);

  a_r7_slow_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (gov_mode == 2'd2) |-> ($countones(active) <= SLOW_LIMIT));

  a_r6_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    gov_mode != 2'd3);

  a_r8_mode_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (gov_mode != $past(gov_mode)) |-> $past(recov_done || done_valid));
endmodule

bind txn_timeout_governor txn_timeout_governor_chk #(
  .NUM_SLOTS  (NUM_SLOTS),
  .SLOW_LIMIT (SLOW_LIMIT)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .issue_grant    (issue_grant),
  .recov_req      (recov_req),
  .recov_done     (recov_done),
  .done_valid     (done_valid),
  .adapt_route_en (adapt_route_en),
  .gov_mode       (gov_mode),
  .active         (active)
);

// File: tb/test_txn_timeout_governor.sv
module test_txn_timeout_governor;
  localparam int CLK_PERIOD = 10;
  localparam int NS   = 4;
  localparam int TO   = 3;
  localparam int SLIM = 1;
  localparam int EXC  = 3;

  logic clk, rst_n;
  logic issue_req, done_valid, ckpt_tick, recov_done;
  logic [1:0] done_slot;
  logic issue_grant, recov_req, adapt_route_en;
  logic [1:0] grant_slot, gov_mode;
  logic k_grant, k_recov, k_adapt;
  logic [1:0] k_gslot, k_mode;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // behavioural model state
  int  m_act [NS];
  int  m_cnt [NS];
  bit  m_recov;
  int  m_mode;
  int  m_exit;
  bit  m_everslow;
  // last sampled outputs
  bit  s_grant, s_recov, s_adapt, s_kadapt;
  int  s_gslot, s_mode;

  txn_timeout_governor #(.NUM_SLOTS(NS), .TIMEOUT_TICKS(TO), .SLOW_LIMIT(SLIM),
    .EXIT_COUNT(EXC), .ROUTE_POLICY(0)) i_txn_timeout_governor (
    .clk(clk), .rst_n(rst_n), .issue_req(issue_req), .issue_grant(issue_grant),
    .grant_slot(grant_slot), .done_valid(done_valid), .done_slot(done_slot),
    .ckpt_tick(ckpt_tick), .recov_done(recov_done), .recov_req(recov_req),
    .adapt_route_en(adapt_route_en), .gov_mode(gov_mode));

  txn_timeout_governor #(.NUM_SLOTS(NS), .TIMEOUT_TICKS(TO), .SLOW_LIMIT(SLIM),
    .EXIT_COUNT(EXC), .ROUTE_POLICY(1)) i_txn_timeout_governor_keep (
    .clk(clk), .rst_n(rst_n), .issue_req(issue_req), .issue_grant(k_grant),
    .grant_slot(k_gslot), .done_valid(done_valid), .done_slot(done_slot),
    .ckpt_tick(ckpt_tick), .recov_done(recov_done), .recov_req(k_recov),
    .adapt_route_en(k_adapt), .gov_mode(k_mode));

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int m_occ();
    int n = 0;
    for (int i = 0; i < NS; i++) n += m_act[i];
    return n;
  endfunction

  function automatic int m_free();
    for (int i = 0; i < NS; i++) if (m_act[i] == 0) return i;
    return 0;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < NS; i++) begin
      m_act[i] = 0;
      m_cnt[i] = 0;
    end
    m_recov = 0; m_mode = 0; m_exit = 0; m_everslow = 0;
  endtask

  // one cycle: drive after negedge, compare, then advance model at posedge
  task automatic step(input bit ir, input bit dv, input int ds,
                      input bit tk, input bit rd);
    int  lim, gs;
    bit  g, tohit, comp;
    @(negedge clk);
    issue_req = ir; done_valid = dv; done_slot = 2'(ds);
    ckpt_tick = tk; recov_done = rd;
    #1;
    lim = (m_mode == 2) ? SLIM : NS;
    g   = ir && !m_recov && (m_occ() < lim);
    gs  = m_free();
    check("R2 issue_grant", int'(issue_grant), int'(g));
    if (g) check("R2 grant_slot", int'(grant_slot), gs);
    check("R4 recov_req", int'(recov_req), int'(m_recov));
    check("R6 gov_mode", int'(gov_mode), m_mode);
    check("R9 adapt_route_en", int'(adapt_route_en), int'(m_mode != 2));
    check("R9 adapt_route_en keep", int'(k_adapt),
          int'(m_mode != 2 && !m_everslow));
    check("R7 keep mode", int'(k_mode), m_mode);
    s_grant = issue_grant; s_gslot = int'(grant_slot); s_recov = recov_req;
    s_mode = int'(gov_mode); s_adapt = adapt_route_en; s_kadapt = k_adapt;
    @(posedge clk);
    if (m_recov && rd) begin
      for (int i = 0; i < NS; i++) begin
        m_act[i] = 0;
        m_cnt[i] = 0;
      end
      m_exit = 0;
      if (m_mode == 0) m_mode = 1;
      else begin
        m_mode = 2;
        m_everslow = 1;
      end
      m_recov = 0;
    end else begin
      tohit = 0; comp = 0;
      for (int s = 0; s < NS; s++) begin
        if (g && s == gs) begin
          m_act[s] = 1; m_cnt[s] = 0;
        end else if (dv && ds == s && m_act[s] == 1) begin
          m_act[s] = 0; comp = 1;
        end else if (tk && m_act[s] == 1) begin
          if (m_cnt[s] == TO - 1) tohit = 1;
          if (m_cnt[s] < TO) m_cnt[s]++;
        end
      end
      if (!m_recov && comp && m_mode != 0) begin
        if (m_exit == EXC - 1) begin
          m_mode = 0; m_exit = 0;
        end else m_exit++;
      end
      if (!m_recov && tohit) m_recov = 1;
    end
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0); endtask
  task automatic tick(); step(0, 0, 0, 1, 0); endtask
  task automatic done(input int s); step(0, 1, s, 0, 0); endtask
  task automatic req(); step(1, 0, 0, 0, 0); endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    issue_req = 0; done_valid = 0; done_slot = 0; ckpt_tick = 0; recov_done = 0;
    rst_n = 0;
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    check("R1 reset recov_req", int'(recov_req), 0);
    check("R1 reset gov_mode", int'(gov_mode), 0);
    check("R1 reset adapt_route_en", int'(adapt_route_en), 1);
    check("R1 reset issue_grant", int'(issue_grant), 0);

    // fill all slots, then one more is refused
    for (int i = 0; i < NS; i++) begin
      req();
      check("R2 lowest slot", s_gslot, i);
    end
    req();
    check("R3 full refuse", int'(s_grant), 0);
    done(1);
    req();
    check("R2 freed slot reused", s_gslot, 1);
    for (int i = 0; i < NS; i++) done(i);

    // completion on the same cycle as the last tick: no timeout
    req();
    tick(); tick();
    step(0, 1, 0, 1, 0);
    idle();
    check("R10 done beats tick", int'(s_recov), 0);

    // hang one transaction through three ticks
    req();
    tick(); tick();
    idle();
    check("R4 no early timeout", int'(s_recov), 0);
    tick();
    req();
    check("R4 timeout raised", int'(s_recov), 1);
    check("R5 grant blocked", int'(s_grant), 0);
    idle();
    check("R5 request held", int'(s_recov), 1);
    step(0, 0, 0, 0, 1);
    idle();
    check("R6 retry mode", s_mode, 1);
    check("R6 adaptive kept", int'(s_adapt), 1);
    check("R5 recov cleared", int'(s_recov), 0);
    for (int i = 0; i < NS; i++) begin
      req();
      check("R5 slots freed", int'(s_grant), 1);
    end

    // retry exit: the completion of a free slot does not count
    done(0);
    done(0);
    done(1);
    idle();
    check("R10 free-slot done ignored", s_mode, 1);
    done(2);
    idle();
    check("R8 retry exit", s_mode, 0);

    // slot 3 hangs: normal -> retry
    tick(); tick(); tick();
    step(0, 0, 0, 0, 1);
    idle();
    check("R6 retry again", s_mode, 1);
    // hang again in retry -> slow-start
    req();
    tick(); tick(); tick();
    step(0, 0, 0, 0, 1);
    idle();
    check("R7 slow mode", s_mode, 2);
    check("R7 adaptive off", int'(s_adapt), 0);
    req();
    req();
    check("R7 slow limit", int'(s_grant), 0);
    done(0);
    req(); done(0);
    req(); done(0);
    idle();
    check("R8 slow exit", s_mode, 0);
    check("R9 adaptive restored", int'(s_adapt), 1);
    check("R9 adaptive kept off", int'(s_kadapt), 0);

    // randomized mix
    for (int c = 0; c < 3000; c++) begin
      step(($urandom % 2) == 0, ($urandom % 3) == 0, int'($urandom % NS),
           ($urandom % 8) == 0, m_recov && (($urandom % 4) == 0));
    end

    finish_run();
  end
endmodule